// File: doc/BRIEF.md
# Serial configuration port

This block is a write-only, three-wire configuration port. An external controller drives a serial clock, a serial data line and a latch strobe. Each rising edge of the serial clock moves one data bit into a 16-bit shift register, most significant bit first. A rising edge of the strobe takes the upper byte of that register as a register address and writes the lower byte into the addressed 8-bit configuration register. The last eight bits shifted in are therefore always the committed data.

All three serial wires are brought into the system clock domain through two-flop synchronisers. Edges are detected after synchronisation, so the serial clock and the strobe must each stay high and stay low for several system clock periods.

Four 8-bit registers are driven out in parallel to the rest of the chip: a mode register, a limit register and two offset calibration registers. An active-high master reset acts asynchronously. It puts the mode and limit registers back to their defaults and clears both calibration registers.

Top module: `cfg_serial_port`

## Requirements
- R1: Data is sampled on the synchronised rising edge of `cfg_clk_i` and enters the shift register at bit 0, so the first bit sent ends up in bit 15 of a 16-bit word once all 16 bits are in. A falling edge shifts nothing.
- R2: Only the 16 most recent bits count; bits shifted before them have no effect on a commit.
- R3: A rising edge of `cfg_lat_i` writes word bits [7:0] into the register whose address is word bits [15:8]: address 0 is `mode_o`, 1 is `limit_o`, 2 is `cal_a_o` and 3 is `cal_b_o`. The other three registers keep their values.
- R4: Holding `cfg_lat_i` high, or lowering it, commits nothing. Bits shifted while the strobe stays high reach a register only at the next rising edge of the strobe.
- R5: A strobe edge whose address is 4 or above changes no register.
- R6: While `master_rst` is high, `mode_o` reads 0x14 and `limit_o` reads 0x80. These values appear asynchronously, without waiting for a clock edge.
- R7: While `master_rst` is high, `cal_a_o` and `cal_b_o` read 0x00.
- R8: When a serial clock rising edge and a strobe rising edge are detected in the same system clock cycle, the commit uses the 16 bits shifted before that edge. The coinciding bit still enters the shift register.
- R9: After `cfg_lat_i` rises between system clock edges, the addressed register changes at the third rising edge of `clk`, and not before.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| master_rst | input | 1 | Asynchronous active-high master reset |
| cfg_clk_i | input | 1 | Serial configuration clock (asynchronous) |
| cfg_dat_i | input | 1 | Serial configuration data, MSB first |
| cfg_lat_i | input | 1 | Commit strobe, active on its rising edge |
| mode_o | output | 8 | Mode register (address 0) |
| limit_o | output | 8 | Limit register (address 1) |
| cal_a_o | output | 8 | Offset calibration register A (address 2) |
| cal_b_o | output | 8 | Offset calibration register B (address 3) |

## Verification
Two functions can fall in the same system clock cycle: a shift of one bit and a commit of the word. The bench provokes this by raising the serial clock and the strobe in the same system clock period. The first word is chosen so that the result shows whether the commit took the word as it stood before the shift. The bench then sends 15 further bits and strobes again. The word it builds, 0x0344, is accepted only if the coinciding bit went into the shift register. If that bit was lost, the word becomes 0x8344, whose address is out of range, so the register would stay unchanged.

// File: rtl/cfgp_pkg.sv
`timescale 1ns/1ps
package cfgp_pkg;
    localparam int SHIFT_W    = 16;
    localparam int DATA_W     = 8;
    localparam int NUM_REGS   = 4;
    localparam int SYNC_DEPTH = 2;
    // reset image, register 0 in the least significant byte
    localparam logic [NUM_REGS*DATA_W-1:0] RST_IMAGE = 32'h0000_8014;
endpackage

// File: rtl/cfgp_sync.sv
`timescale 1ns/1ps
module cfgp_sync #(
    parameter int STAGES = 2,
    parameter int WIDTH  = 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);
    logic [WIDTH-1:0] stg_d [STAGES];
    logic [WIDTH-1:0] stg_q [STAGES];

    always_comb begin
        stg_d[0] = async_i;
        for (int i = 1; i < STAGES; i++) stg_d[i] = stg_q[i-1];
    end

    always_ff @(posedge clk or posedge rst) begin
        if (rst) begin
            for (int i = 0; i < STAGES; i++) stg_q[i] <= '0;
        end else begin
            for (int i = 0; i < STAGES; i++) stg_q[i] <= stg_d[i];
        end
    end

    assign sync_o = stg_q[STAGES-1];
endmodule

// File: rtl/cfgp_frontend.sv
`timescale 1ns/1ps
module cfgp_frontend #(
    parameter int SHIFT_W = cfgp_pkg::SHIFT_W
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               sclk_s,
    input  logic               sdat_s,
    input  logic               slat_s,
    output logic [SHIFT_W-1:0] word_o,
    output logic               commit_o
);
    typedef struct packed {
        logic               sclk_prev;
        logic               slat_prev;
        logic [SHIFT_W-1:0] sh;
    } fe_state_t;

    fe_state_t st_d, st_q;
    logic      shift_en;

    always_comb begin
        st_d           = st_q;
        shift_en       = sclk_s & ~st_q.sclk_prev;
        commit_o       = slat_s & ~st_q.slat_prev;
        st_d.sclk_prev = sclk_s;
        st_d.slat_prev = slat_s;
        if (shift_en) st_d.sh = {st_q.sh[SHIFT_W-2:0], sdat_s};
    end

    always_ff @(posedge clk or posedge rst) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    // the word seen by a commit is the one held before any coinciding shift
    assign word_o = st_q.sh;

    p_shift_msb_first_r1: assert property (@(posedge clk) disable iff (rst)
        shift_en |=> word_o == {$past(word_o[SHIFT_W-2:0]), $past(sdat_s)});

    p_no_edge_holds_r1: assert property (@(posedge clk) disable iff (rst)
        !shift_en |=> $stable(word_o));
endmodule

// File: rtl/cfgp_regbank.sv
`timescale 1ns/1ps
module cfgp_regbank #(
    parameter int SHIFT_W  = cfgp_pkg::SHIFT_W,
    parameter int DATA_W   = cfgp_pkg::DATA_W,
    parameter int NUM_REGS = cfgp_pkg::NUM_REGS,
    parameter logic [NUM_REGS*DATA_W-1:0] RST_IMAGE = cfgp_pkg::RST_IMAGE
) (
    input  logic                             clk,
    input  logic                             rst,
    input  logic                             commit_i,
    input  logic [SHIFT_W-1:0]               word_i,
    output logic [NUM_REGS-1:0][DATA_W-1:0]  bank_o
);
    localparam int ADDR_W = SHIFT_W - DATA_W;
    localparam int IDX_W  = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1;

    logic [NUM_REGS-1:0][DATA_W-1:0] bank_d, bank_q;
    logic [ADDR_W-1:0]               addr;
    logic [DATA_W-1:0]               data;
    logic                            addr_hit;

    assign addr     = word_i[SHIFT_W-1 -: ADDR_W];
    assign data     = word_i[DATA_W-1:0];
    assign addr_hit = addr < ADDR_W'(NUM_REGS);

    always_comb begin
        bank_d = bank_q;
        if (commit_i && addr_hit) bank_d[addr[IDX_W-1:0]] = data;
    end

    always_ff @(posedge clk or posedge rst) begin
        if (rst) bank_q <= RST_IMAGE;
        else     bank_q <= bank_d;
    end

    assign bank_o = bank_q;

    p_quiet_without_strobe_r4: assert property (@(posedge clk) disable iff (rst)
        !commit_i |=> $stable(bank_o));

    p_write_lands_r3: assert property (@(posedge clk) disable iff (rst)
        (commit_i && addr_hit) |=> bank_o[$past(addr[IDX_W-1:0])] == $past(data));

    p_bad_addr_ignored_r5: assert property (@(posedge clk) disable iff (rst)
        (commit_i && !addr_hit) |=> $stable(bank_o));

    // R6 and R7: reset image held while reset is high
    p_reset_image_r6: assert property (@(posedge clk)
        rst |-> bank_o == RST_IMAGE);
endmodule

// File: rtl/cfg_serial_port.sv
`timescale 1ns/1ps
module cfg_serial_port #(
    parameter int SHIFT_W    = cfgp_pkg::SHIFT_W,
    parameter int DATA_W     = cfgp_pkg::DATA_W,
    parameter int NUM_REGS   = cfgp_pkg::NUM_REGS,
    parameter int SYNC_DEPTH = cfgp_pkg::SYNC_DEPTH
) (
    input  logic              clk,
    input  logic              master_rst,
    input  logic              cfg_clk_i,
    input  logic              cfg_dat_i,
    input  logic              cfg_lat_i,
    output logic [DATA_W-1:0] mode_o,
    output logic [DATA_W-1:0] limit_o,
    output logic [DATA_W-1:0] cal_a_o,
    output logic [DATA_W-1:0] cal_b_o
);
    logic [2:0]                      pins_s;
    logic [SHIFT_W-1:0]              word;
    logic                            commit;
    logic [NUM_REGS-1:0][DATA_W-1:0] bank;

    cfgp_sync #(.STAGES(SYNC_DEPTH), .WIDTH(3)) u_sync (
        .clk(clk), .rst(master_rst),
        .async_i({cfg_lat_i, cfg_dat_i, cfg_clk_i}),
        .sync_o(pins_s)
    );

    cfgp_frontend #(.SHIFT_W(SHIFT_W)) u_front (
        .clk(clk), .rst(master_rst),
        .sclk_s(pins_s[0]), .sdat_s(pins_s[1]), .slat_s(pins_s[2]),
        .word_o(word), .commit_o(commit)
    );

    cfgp_regbank #(.SHIFT_W(SHIFT_W), .DATA_W(DATA_W), .NUM_REGS(NUM_REGS)) u_bank (
        .clk(clk), .rst(master_rst),
        .commit_i(commit), .word_i(word), .bank_o(bank)
    );

    assign mode_o  = bank[0];
    assign limit_o = bank[1];
    assign cal_a_o = bank[2];
    assign cal_b_o = bank[3];
endmodule

// File: tb/cfg_serial_port_tb_top.sv
`timescale 1ns/1ps
module cfg_serial_port_tb_top;
    logic       clk = 1'b0;
    logic       master_rst;
    logic       cfg_clk_i, cfg_dat_i, cfg_lat_i;
    logic [7:0] mode_o, limit_o, cal_a_o, cal_b_o;
    int         n_chk = 0;
    int         n_fail = 0;

    always #5 clk = ~clk;

    cfg_serial_port dut_i (
        .clk(clk), .master_rst(master_rst),
        .cfg_clk_i(cfg_clk_i), .cfg_dat_i(cfg_dat_i), .cfg_lat_i(cfg_lat_i),
        .mode_o(mode_o), .limit_o(limit_o), .cal_a_o(cal_a_o), .cal_b_o(cal_b_o)
    );

    // {word, expected {mode, limit, cal_a, cal_b}}
    localparam int NV = 8;
    localparam logic [47:0] VEC [NV] = '{
        {16'h0155, 32'h14_55_00_00},
        {16'h00A3, 32'hA3_55_00_00},
        {16'h027F, 32'hA3_55_7F_00},
        {16'h0381, 32'hA3_55_7F_81},
        {16'h04FF, 32'hA3_55_7F_81},
        {16'hFF00, 32'hA3_55_7F_81},
        {16'h0300, 32'hA3_55_7F_00},
        {16'h0201, 32'hA3_55_01_00}
    };

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string req, input logic [31:0] exp);
        logic [31:0] act;
        act = {mode_o, limit_o, cal_a_o, cal_b_o};
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic send_bit(input logic b);
        cfg_dat_i = b;
        wait_clk(3);
        cfg_clk_i = 1'b1;
        wait_clk(4);
        cfg_clk_i = 1'b0;
        wait_clk(3);
    endtask

    task automatic send_bits(input logic [15:0] w, input int n);
        for (int i = n - 1; i >= 0; i--) send_bit(w[i]);
    endtask

    task automatic strobe();
        cfg_lat_i = 1'b1;
        wait_clk(6);
        cfg_lat_i = 1'b0;
        wait_clk(5);
    endtask

    initial begin
        #1_000_000;
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        master_rst = 1'b1;
        cfg_clk_i  = 1'b0;
        cfg_dat_i  = 1'b0;
        cfg_lat_i  = 1'b0;
        wait_clk(4);
        check("R6_R7 reset image", 32'h14_80_00_00);
        master_rst = 1'b0;
        wait_clk(3);
        check("R6 after release", 32'h14_80_00_00);

        for (int v = 0; v < NV; v++) begin
            send_bits(VEC[v][47:32], 16);
            strobe();
            check((VEC[v][47:40] >= 8'd4) ? "R5 bad address" : "R1_R3 write",
                  VEC[v][31:0]);
        end

        // R2: 24 bits sent, only the last 16 count
        send_bits(16'h00AB, 8);
        send_bits(16'h0233, 16);
        strobe();
        check("R2 last sixteen bits", 32'hA3_55_33_00);

        // R4: strobe held high does not commit new bits
        send_bits(16'h0311, 16);
        cfg_lat_i = 1'b1;
        wait_clk(6);
        check("R4 first edge", 32'hA3_55_33_11);
        send_bits(16'h0322, 16);
        cfg_lat_i = 1'b0;
        wait_clk(6);
        check("R4 held high and falling", 32'hA3_55_33_11);
        strobe();
        check("R4 next rising edge", 32'hA3_55_33_22);

        // R9: latency from strobe to register
        send_bits(16'h0177, 16);
        cfg_lat_i = 1'b1;
        wait_clk(2);
        check("R9 before third edge", 32'hA3_55_33_22);
        wait_clk(1);
        check("R9 at third edge", 32'hA3_77_33_22);
        cfg_lat_i = 1'b0;
        wait_clk(5);

        // R8: shift and commit in the same cycle
        send_bits(16'h0267, 16);
        cfg_dat_i = 1'b0;
        wait_clk(3);
        cfg_clk_i = 1'b1;
        cfg_lat_i = 1'b1;
        wait_clk(6);
        cfg_clk_i = 1'b0;
        cfg_lat_i = 1'b0;
        wait_clk(4);
        check("R8 commit uses pre-shift word", 32'hA3_77_67_22);
        send_bits(16'h0344, 15);
        strobe();
        check("R8 coinciding bit retained", 32'hA3_77_67_44);

        // R6/R7: asynchronous reset between clock edges
        @(negedge clk);
        #1 master_rst = 1'b1;
        #1 check("R6_R7 async reset", 32'h14_80_00_00);
        wait_clk(12);
        master_rst = 1'b0;
        wait_clk(3);
        check("R7 calibration cleared", 32'h14_80_00_00);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule